// File: doc/BRIEF.md
# Quarter-Wave Sine Phase-to-Amplitude Converter

This block turns an unsigned phase word into a signed sine sample. The phase word covers exactly one full turn, so arithmetic on it wraps around the circle by itself. Only the first quarter of the wave is stored, as a table of unsigned magnitudes. The two top phase bits choose the quadrant. One bit reverses the direction in which the table is read, and the other bit flips the sign of the result. The next field of phase bits selects a table segment. The lowest bits are used to interpolate linearly between the two ends of that segment.

The table is built when the design is elaborated, using a constant function, and nothing is loaded from a file. A phase word comes in with a valid strobe. A sample goes out with its own valid strobe a fixed three clocks later, and a new phase can be accepted on every clock. A phase accumulator drives this block, and a mixer or converter consumes its output.

Top module: `qsine_top`

## Requirements
- R1: While `rstN` is low, `outValid` is 0 and `sample` is 0.
- R2: A phase presented with `inValid` high before clock edge N gives its sample, with `outValid` high, after edge N+2, which is the third edge counting the one that accepts it. Back-to-back inputs give back-to-back outputs, and `outValid` is low in every other cycle.
- R3: The stored table has 1025 entries. Entry k is round(32767·sin(k·π/2048)), so entry 0 is 0 and entry 1024 is 32767. For a phase whose bits [15:14] are 00, bits [13:4] give k and bits [3:0] give the fraction f. When f is 0, the output equals entry k.
- R4: When f is not 0, the magnitude is entry k plus floor((entry k+1 − entry k)·f / 16).
- R5: When phase bit 14 is 1, bits [13:0] are replaced by their one's complement before k and f are taken. For example, 0x4000 reads k=1023 with f=15, and 0x7FFF reads k=0 with f=0.
- R6: When phase bit 15 is 1, the output is the negated magnitude. The magnitude is otherwise computed exactly as in R3 to R5.
- R7: The output never equals −32768 (0x8000). For any phase p, the sample for p XOR 0x8000 is the exact negation of the sample for p.
- R8: `sample` holds its last value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Phase word is valid this cycle |
| phase | input | 16 | Unsigned phase; a full turn spans the word |
| outValid | output | 1 | Sample is new this cycle |
| sample | output | 16 | Two's-complement sine sample |

## Verification
The bench aims at the quadrant seams. Phases 0x3FF0, 0x4000, 0x7FFF, 0x8000, 0xBFF0 and 0xFFFF show whether the mirror also complements the fraction and reads entry k+1 at the top of the table. A design that skipped either step would produce a step or a sign flip at 90° or 270°. Single-step phases inside the first segment near zero expose interpolation that truncates, or that shifts with the wrong sign. A flip of the top bit checks that negation is exact and never produces 0x8000. Bursts separated by gaps catch a valid strobe with the wrong latency, and a sample that drifts while no result is being produced.

// File: rtl/qsine_pkg.sv
package qsine_pkg;

  typedef struct packed {
    logic loadSplit;
    logic loadRead;
    logic loadOut;
  } qsStrobes_t;

  // Rounded quarter-wave magnitude for entry k of a table with 2**addrW segments.
  function automatic int sineEntry(input int k, input int addrW, input int magW);
    real x;
    real term;
    real acc;
    int  full;
    int  res;
    full = (1 << magW) - 1;
    x    = real'(k) * 3.14159265358979323846 / (2.0 * real'(1 << addrW));
    term = x;
    acc  = x;
    for (int n = 1; n < 12; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    res = $rtoi(acc * real'(full) + 0.5);
    if (res > full) res = full;
    if (res < 0) res = 0;
    return res;
  endfunction

endpackage

// File: rtl/qsine_ctrl.sv
module qsine_ctrl
  import qsine_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output qsStrobes_t strobes,
  output logic       outValid
);

  logic [STAGES-1:0] vldPipe;

  always_ff @(posedge clk) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.loadSplit = inValid;
    strobes.loadRead  = vldPipe[0];
    strobes.loadOut   = vldPipe[1];
  end

  assign outValid = vldPipe[STAGES-1];

endmodule

// File: rtl/qsine_dp.sv
module qsine_dp
  import qsine_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  qsStrobes_t         strobes,
  input  logic [PHASE_W-1:0] phase,
  output logic [OUT_W-1:0]   sample
);

  localparam int LOW_W  = PHASE_W - 2;
  localparam int FRAC_W = LOW_W - ADDR_W;
  localparam int MAG_W  = OUT_W - 1;
  localparam int TBL_N  = (1 << ADDR_W) + 1;
  localparam int MAX_M  = (1 << MAG_W) - 1;

  // Quarter table, computed at elaboration.
  logic [MAG_W-1:0] rom [TBL_N];
  for (genvar i = 0; i < TBL_N; i++) begin : g_rom
    assign rom[i] = MAG_W'(sineEntry(i, ADDR_W, MAG_W));
  end

  // Stage 1: mirror and split.
  logic [LOW_W-1:0]  lowMir;
  logic [ADDR_W-1:0] idxS1;
  logic [FRAC_W-1:0] fracS1;
  logic              negS1;

  assign lowMir = phase[LOW_W-1:0] ^ {LOW_W{phase[PHASE_W-2]}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxS1  <= '0;
      fracS1 <= '0;
      negS1  <= 1'b0;
    end else if (strobes.loadSplit) begin
      idxS1  <= lowMir[LOW_W-1:FRAC_W];
      fracS1 <= lowMir[FRAC_W-1:0];
      negS1  <= phase[PHASE_W-1];
    end
  end

  // Stage 2: read both segment ends.
  logic [ADDR_W:0]   idxHi;
  logic [MAG_W-1:0]  loS2;
  logic [MAG_W-1:0]  hiS2;
  logic [FRAC_W-1:0] fracS2;
  logic              negS2;

  assign idxHi = {1'b0, idxS1} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loS2   <= '0;
      hiS2   <= '0;
      fracS2 <= '0;
      negS2  <= 1'b0;
    end else if (strobes.loadRead) begin
      loS2   <= rom[idxS1];
      hiS2   <= rom[idxHi];
      fracS2 <= fracS1;
      negS2  <= negS1;
    end
  end

  // Stage 3: interpolate, apply sign, saturate.
  logic signed [OUT_W-1:0]   diff;
  logic signed [OUT_W-1:0]   fracS;
  logic signed [2*OUT_W-1:0] prod;
  logic signed [2*OUT_W-1:0] magSum;
  logic signed [2*OUT_W-1:0] magSat;
  logic signed [2*OUT_W-1:0] signedVal;
  logic [OUT_W-1:0]          nextSample;

  always_comb begin
    diff   = $signed({1'b0, hiS2}) - $signed({1'b0, loS2});
    fracS  = $signed({{(OUT_W-FRAC_W){1'b0}}, fracS2});
    prod   = diff * fracS;
    magSum = $signed({{(OUT_W+1){1'b0}}, loS2}) + (prod >>> FRAC_W);
    if (magSum > MAX_M)  magSat = MAX_M;
    else if (magSum < 0) magSat = '0;
    else                 magSat = magSum;
    signedVal  = negS2 ? -magSat : magSat;
    nextSample = signedVal[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                sample <= '0;
    else if (strobes.loadOut) sample <= nextSample;
  end

endmodule

// File: rtl/qsine_top.sv
module qsine_top
  import qsine_pkg::*;
#(
  parameter int PHASE_W = 16,
  parameter int ADDR_W  = 10,
  parameter int OUT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [PHASE_W-1:0] phase,
  output logic               outValid,
  output logic [OUT_W-1:0]   sample
);

  qsStrobes_t strobes;

  qsine_ctrl #(.STAGES(3)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  qsine_dp #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .phase   (phase),
    .sample  (sample)
  );

endmodule

// File: rtl/qsine_chk.sv
module qsine_chk #(
  parameter int PHASE_W = 16,
  parameter int OUT_W   = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [PHASE_W-1:0] phase,
  input logic               outValid,
  input logic [OUT_W-1:0]   sample
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)               sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
  end

  // R2: valid appears exactly three cycles after the phase is accepted.
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R6: a phase with the top bit set never yields a positive sample.
  a_r6_neg_half: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && $past(phase[PHASE_W-1], 3)) |-> sample[OUT_W-1] || sample == '0);

  // R6: a phase with the top bit clear never yields a negative sample.
  a_r6_pos_half: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3 && outValid && !$past(phase[PHASE_W-1], 3)) |-> !sample[OUT_W-1]);

  // R7: the most negative code is never produced.
  a_r7_no_min: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> sample != {1'b1, {(OUT_W-1){1'b0}}});

  // R8: sample is held while no result is produced.
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd0 && !outValid) |-> $stable(sample));

endmodule

bind qsine_top qsine_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .phase    (phase),
  .outValid (outValid),
  .sample   (sample)
);

// File: tb/test_qsine_top.sv
module test_qsine_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] phase = '0;
  logic        outValid;
  logic [15:0] sample;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    val;
    int    due;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qsine_top i_qsine_top (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .phase    (phase),
    .outValid (outValid),
    .sample   (sample)
  );

  function automatic int tblVal(input int k);
    return $rtoi($sin(real'(k) * 3.14159265358979323846 / 2048.0) * 32767.0 + 0.5);
  endfunction

  function automatic int modelOut(input logic [15:0] p);
    logic [13:0] low;
    int k, f, mag;
    low = p[14] ? ~p[13:0] : p[13:0];
    k   = int'(low[13:4]);
    f   = int'(low[3:0]);
    mag = tblVal(k) + ((tblVal(k + 1) - tblVal(k)) * f) / 16;
    return p[15] ? -mag : mag;
  endfunction

  function automatic string tagOf(input logic [15:0] p);
    if (p[15])            return "R6";
    if (p[14])            return "R5";
    if (p[3:0] != 4'd0)   return "R4";
    return "R3";
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] p);
    expItem_t it;
    @(negedge clk);
    inValid = 1'b1;
    phase   = p;
    it.val = modelOut(p);
    it.due = cyc + 3;
    it.tag = tagOf(p);
    sbQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      phase   = 16'hA5A5;
    end
  endtask

  // Monitor / scoreboard.
  initial begin
    logic [15:0] lastSample;
    bit          seen;
    seen = 1'b0;
    lastSample = '0;
    forever begin
      @(posedge clk);
      #2;
      if (rstN && !done) begin
        if (outValid) begin
          if (sbQ.size() == 0) begin
            check(1'b0, "R2 unexpected valid", 1, 0);
          end else begin
            expItem_t it;
            it = sbQ.pop_front();
            check(cyc == it.due, "R2 latency", cyc, it.due);
            check($signed(sample) == it.val, it.tag, $signed(sample), it.val);
            check(sample != 16'h8000, "R7 min code", $signed(sample), -32767);
          end
        end else begin
          if (sbQ.size() != 0)
            check(cyc < sbQ[0].due, "R2 missing valid", cyc, sbQ[0].due);
          if (seen)
            check(sample == lastSample, "R8 hold", $signed(sample), $signed(lastSample));
        end
        lastSample = sample;
        seen = 1'b1;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset state.
    repeat (4) @(posedge clk);
    #2;
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(sample == 16'h0000, "R1 sample", sample, 0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R3 exact entries, R4 interpolation, back-to-back (R2).
    drive(16'h0000);
    drive(16'h0010);
    drive(16'h3FF0);
    drive(16'h0001);
    drive(16'h0008);
    drive(16'h000F);
    drive(16'h1234);
    // R5 mirrored quadrant seams.
    drive(16'h4000);
    drive(16'h7FFF);
    drive(16'h5555);
    drive(16'h7FF0);
    idle(5);
    // R6 negated halves, R7 symmetry at the seams.
    drive(16'h8000);
    drive(16'hBFF0);
    drive(16'hC000);
    drive(16'hFFFF);
    drive(16'h8010);
    drive(16'h9234);
    drive(16'h3FFF);
    drive(16'hBFFF);
    idle(1);
    drive(16'h4000);
    idle(3);
    drive(16'hC000);
    idle(6);

    // R7: pairs p and p^0x8000, spaced with random gaps.
    for (int i = 0; i < 400; i++) begin
      logic [15:0] p;
      p = 16'($urandom);
      drive(p);
      drive(p ^ 16'h8000);
      if ($urandom_range(3) == 0) idle($urandom_range(4) + 1);
    end
    idle(8);

    check(sbQ.size() == 0, "R2 outstanding", sbQ.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule